// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits beside the program counter of a simple in-order fetch unit and runs hardware loops without spending any instruction cycles on the loop branch. A loop command supplies a body start address, a body end address, an 8-bit pass count and a mode. From the next cycle the controller watches the fetch address. Each time that address equals the body end and more passes remain, it overrides the next fetch address with the body start in the same cycle.

In block mode the body can be any run of instructions. In repeat mode the end operand is ignored, and the single instruction at the start address is fetched again and again. A loaded count of zero stands for the largest pass count, 256, and never for zero passes.

While a loop runs, the controller asserts an interrupt-mask output, so that a repeat is not broken up. A loop command that arrives while a loop is already running is dropped, and an error pulse reports it.

Top module: `zol_loop_ctrl`

## Requirements
- R1: After reset, loop_active_o, irq_mask_o, next_pc_valid_o and start_error_o are all 0.
- R2: A start_valid_i accepted while no loop runs makes loop_active_o 1 from the next cycle.
- R3: While a loop runs and pc_i equals the body end with more passes left, next_pc_valid_o is 1 in that same cycle and next_pc_o equals the captured body start.
- R4: A count N from 1 to 255 yields exactly N passes through the body, which is N-1 redirects. A count of 1 yields no redirect.
- R5: A count of 0 yields 256 passes, which is 255 redirects.
- R6: On the last pass, no redirect is made at the body end, so fetch falls through to end+1, and loop_active_o is 0 from the next cycle.
- R7: start_mode_i = 1 selects repeat mode. start_last_i is ignored, and the instruction at the start address is fetched once per pass. start_mode_i = 0 selects block mode.
- R8: irq_mask_o equals loop_active_o in every cycle, in both modes.
- R9: A start_valid_i while a loop runs is ignored, so the running loop keeps its operands and count. start_error_o is 1 in the following cycle only.
- R10: next_pc_valid_o is 0 whenever no loop runs or pc_i differs from the body end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | ADDR_W | Address being fetched this cycle |
| start_valid_i | input | 1 | Loop command strobe |
| start_mode_i | input | 1 | 0 = block loop, 1 = single-instruction repeat |
| start_first_i | input | ADDR_W | Body start address |
| start_last_i | input | ADDR_W | Body end address (block mode only) |
| start_count_i | input | CNT_W | Pass count, 0 means 2**CNT_W |
| next_pc_valid_o | output | 1 | Override the next fetch address |
| next_pc_o | output | ADDR_W | Override address |
| loop_active_o | output | 1 | A loop is running |
| irq_mask_o | output | 1 | Interrupts held off |
| start_error_o | output | 1 | Pulse: a command was dropped |

## Verification
The bench acts as the fetch unit and follows the override, so every loop is checked one cycle at a time. Random loops vary the mode, the body length (1 to 6 instructions) and the count. A body of length one in block mode must act like repeat mode, while the longer bodies show that the redirect fires only at the end address. Directed counts of 0, 1 and 255 separate the wrap to 256 passes from a plain count, and show that a single pass makes no redirect. A second command injected during a loop, carrying different operands, shows that it is dropped: the original loop still ends on its own count and address.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic {
    ZL_BLOCK  = 1'b0,
    ZL_REPEAT = 1'b1
  } zl_mode_e;
endpackage

// File: rtl/zol_frame_reg.sv
module zol_frame_reg
  import zol_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mode_in,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  output zl_mode_e          mode_q,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q
);
  zl_mode_e          mode_d;
  logic [ADDR_W-1:0] last_d;

  // In repeat mode the body is the single start instruction.
  always_comb begin
    mode_d = zl_mode_e'(mode_in);
    last_d = (mode_d == ZL_REPEAT) ? first_in : last_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ZL_BLOCK;
      first_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      mode_q  <= mode_d;
      first_q <= first_in;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/zol_pass_counter.sv
module zol_pass_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             step,
  output logic             final_pass
);
  localparam int PASS_W = CNT_W + 1;

  logic [PASS_W-1:0] left_q;

  // A zero count stands for the full range of the counter.
  function automatic logic [PASS_W-1:0] passes_of(input logic [CNT_W-1:0] c);
    logic [PASS_W-1:0] full;
    full = '0;
    full[CNT_W] = 1'b1;
    return (c == '0) ? full : {1'b0, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= passes_of(count_in);
    end else if (step) begin
      left_q <= left_q - PASS_W'(1);
    end
  end

  assign final_pass = (left_q <= PASS_W'(1));
endmodule

// File: rtl/zol_steer.sv
module zol_steer #(
  parameter int ADDR_W = 16
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] first_q,
  input  logic [ADDR_W-1:0] last_q,
  input  logic              final_pass,
  output logic              end_hit,
  output logic              loop_back,
  output logic              exit_now,
  output logic [ADDR_W-1:0] target
);
  always_comb begin
    end_hit   = active && (pc == last_q);
    loop_back = end_hit && !final_pass;
    exit_now  = end_hit && final_pass;
    target    = first_q;
  end
endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl
  import zol_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              start_valid_i,
  input  logic              start_mode_i,
  input  logic [ADDR_W-1:0] start_first_i,
  input  logic [ADDR_W-1:0] start_last_i,
  input  logic [CNT_W-1:0]  start_count_i,
  output logic              next_pc_valid_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              loop_active_o,
  output logic              irq_mask_o,
  output logic              start_error_o
);
  logic              active_q;
  logic              err_q;
  logic              accept;
  logic              reject;
  logic              end_hit;
  logic              loop_back;
  logic              exit_now;
  logic              final_pass;
  zl_mode_e          mode_q;
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] target;

  assign accept = start_valid_i && !active_q;
  assign reject = start_valid_i && active_q;

  zol_frame_reg #(.ADDR_W(ADDR_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .mode_in  (start_mode_i),
    .first_in (start_first_i),
    .last_in  (start_last_i),
    .mode_q   (mode_q),
    .first_q  (first_q),
    .last_q   (last_q)
  );

  zol_pass_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .count_in   (start_count_i),
    .step       (loop_back),
    .final_pass (final_pass)
  );

  zol_steer #(.ADDR_W(ADDR_W)) u_steer (
    .active     (active_q),
    .pc         (pc_i),
    .first_q    (first_q),
    .last_q     (last_q),
    .final_pass (final_pass),
    .end_hit    (end_hit),
    .loop_back  (loop_back),
    .exit_now   (exit_now),
    .target     (target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept)        active_q <= 1'b1;
      else if (exit_now) active_q <= 1'b0;
    end
  end

  logic unused_mode;
  assign unused_mode = (mode_q == ZL_REPEAT);

  assign next_pc_valid_o = loop_back;
  assign next_pc_o       = target;
  assign loop_active_o   = active_q;
  assign irq_mask_o      = active_q;
  assign start_error_o   = err_q;
endmodule

// File: rtl/zol_loop_ctrl_chk.sv
module zol_loop_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              next_pc_valid,
  input logic              loop_active,
  input logic              irq_mask,
  input logic              start_error,
  input logic              accept,
  input logic              reject,
  input logic              end_hit,
  input logic              exit_now
);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> loop_active);

  a_r6_exit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !next_pc_valid) |=> !loop_active);

  a_r8_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask == loop_active);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> start_error);

  a_r9_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !exit_now) |=> loop_active);

  a_r9_err_only_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !reject |=> !start_error);

  a_r10_idle_no_steer: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |-> !next_pc_valid);

  a_r3_steer_keeps_loop: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_valid |=> loop_active);
endmodule

bind zol_loop_ctrl zol_loop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .next_pc_valid (next_pc_valid_o),
  .loop_active   (loop_active_o),
  .irq_mask      (irq_mask_o),
  .start_error   (start_error_o),
  .accept        (accept),
  .reject        (reject),
  .end_hit       (end_hit),
  .exit_now      (exit_now)
);

// File: tb/sim_zol_loop_ctrl.sv
`timescale 1ns/100ps
module sim_zol_loop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc_i = '0;
  logic        start_valid_i = 1'b0;
  logic        start_mode_i = 1'b0;
  logic [15:0] start_first_i = '0;
  logic [15:0] start_last_i = '0;
  logic [7:0]  start_count_i = '0;
  logic        next_pc_valid_o;
  logic [15:0] next_pc_o;
  logic        loop_active_o;
  logic        irq_mask_o;
  logic        start_error_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  zol_loop_ctrl u0 (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int passes_for(input logic [7:0] c);
    return (c == 8'd0) ? 256 : int'(c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench acts as fetch unit; drives at negedge, samples 1.5 ns later.
  task automatic run_loop(input bit mode, input logic [15:0] f, input logic [15:0] l,
                          input logic [7:0] c, input bit inject);
    int          rem;
    int          redirects;
    int          step;
    logic [15:0] le;
    logic [15:0] pc;
    bit          ov;
    bit          done;
    @(negedge clk);
    pc_i = f - 16'd1;
    start_valid_i = 1'b1;
    start_mode_i  = mode;
    start_first_i = f;
    start_last_i  = l;
    start_count_i = c;
    #1.5;
    check("R10 idle", next_pc_valid_o, 0);
    check("R2 idle before", loop_active_o, 0);
    rem = passes_for(c);
    le = mode ? f : l;
    pc = f;
    redirects = 0;
    step = 0;
    done = 0;
    while (!done) begin
      @(negedge clk);
      pc_i = pc;
      start_valid_i = inject && (step == 1);
      start_mode_i  = ~mode;
      start_first_i = f + 16'h0300;
      start_last_i  = f + 16'h0301;
      start_count_i = 8'd3;
      #1.5;
      if (step == 0) check("R2 active", loop_active_o, 1);
      check("R8 mask", irq_mask_o, loop_active_o);
      check("R9 err pulse", start_error_o, inject && (step == 2));
      ov = (pc == le) && (rem > 1);
      check(mode ? "R7 repeat steer" : "R3 steer", next_pc_valid_o, ov);
      if (ov) begin
        check("R3 target", next_pc_o, f);
        redirects++;
      end
      if (pc == le) begin
        if (rem > 1) rem--; else done = 1;
      end
      pc = ov ? f : pc + 16'd1;
      step++;
    end
    check(c == 0 ? "R5 redirects" : "R4 redirects", redirects, passes_for(c) - 1);
    @(negedge clk);
    pc_i = pc;
    start_valid_i = 1'b0;
    #1.5;
    check("R6 fall through pc", pc, le + 16'd1);
    check("R6 inactive", loop_active_o, 0);
    check("R8 mask off", irq_mask_o, 0);
    check("R10 no steer", next_pc_valid_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 active", loop_active_o, 0);
    check("R1 mask", irq_mask_o, 0);
    check("R1 steer", next_pc_valid_o, 0);
    check("R1 err", start_error_o, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // Directed corners
    run_loop(1'b0, 16'h0100, 16'h0103, 8'd1, 1'b0);   // R4 single pass
    run_loop(1'b0, 16'h0200, 16'h0202, 8'd0, 1'b0);   // R5 block 256
    run_loop(1'b1, 16'h0300, 16'h0777, 8'd0, 1'b0);   // R7 R5 repeat 256
    run_loop(1'b0, 16'h0400, 16'h0405, 8'd255, 1'b0); // R4
    run_loop(1'b0, 16'h0500, 16'h0500, 8'd4, 1'b0);   // length-one body
    run_loop(1'b0, 16'h0600, 16'h0602, 8'd5, 1'b1);   // R9 rejected start
    run_loop(1'b1, 16'h0700, 16'h0900, 8'd6, 1'b1);   // R9 during repeat
    for (int i = 0; i < 20; i++) begin
      logic [15:0] f;
      logic [7:0]  c;
      bit          m;
      f = 16'h1000 + 16'($urandom_range(0, 16'h0E00));
      m = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: c = 8'd0;
        1: c = 8'd1;
        default: c = 8'($urandom_range(2, 40));
      endcase
      run_loop(m, f, f + 16'($urandom_range(0, 5)), c, 1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule